// File: doc/BRIEF.md
# Pipelined ADC Digital Correction

This block sits behind the ten cascaded 1.5-bit stages of a pipelined analog-to-digital converter. Each stage compares its residue against two thresholds and reports a ternary decision of -1, 0 or +1. The decisions of one sample do not reach the block together. Successive stages resolve half a clock apart, so every stage is delayed until its decision lines up with the decision that the last stage makes for the same sample.

Once a sample's decisions are aligned, the block adds them with binary weights that overlap. Stage i carries weight 2^(9-i), and a mid-scale offset is added. The sum is clamped to the 10-bit range and registered as a straight offset binary word. The weights overlap, so a comparator that trips early in one stage is paid back by the next stage. No output code is lost as long as the offset stays inside the redundancy range.

The decision stream runs freely and has no handshake. A pipelined converter cannot be stalled. A new set of decisions arrives on every rising edge, so the consumer must take one output word per clock. There is no back-pressure path.

Top module: `adc_pipe_corr`

## Requirements
- R1: Bits [2i+1:2i] of `stage_dec` carry the decision of stage i (stage 0 is the most significant), encoded as 00 = -1, 01 = 0 and 10 = +1. The illegal code 11 is weighted exactly as +1.
- R2: The decision of stage i for sample n is taken from the rising edge that ends cycle n + floor(i/2). Stages 2k and 2k+1 share one slot: the odd stage resolves half a clock later but still arrives before the same rising edge.
- R3: The word for sample n is on `code_out` during cycle n+5, which is five rising edges after stage 0 presents its decision. Counting the falling-edge sampling half a cycle earlier, the latency from sample to data is 5.5 clock cycles.
- R4: Before clamping, the output value is 512 plus the sum over all stages of d_i times 2^(9-i), where d_i is the decoded decision of stage i.
- R5: A value below 0 gives 0 and a value above 1023 gives 1023. The values 0, 1 and 1023 themselves pass through unchanged.
- R6: The coding is straight offset binary. All-neutral decisions give 10 0000 0000 (bipolar zero, 512), 1023 is positive full scale minus one LSB, and 0 is negative full scale.
- R7: Reset is synchronous and active high. While `rst` is high, `code_out` is 0 after each edge. After release, `code_out` stays 0 for five cycles, whatever the inputs are. The first word that follows belongs to the first post-reset sample.
- R8: Redundant decision patterns give identical codes. For example, (+1 at stage i, -1 at stage i+1) gives the same code as (0, +1). A decision flipped by a comparator offset therefore moves no output code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stage_dec | input | 20 | Two-bit decision per stage, stage i at bits [2i+1:2i] |
| code_out | output | 10 | Registered corrected word, straight offset binary |

## Verification
The hardest case to reach is a stage decision that arrives in the wrong slot. The corrected sum mixes every stage, so a misaligned low-weight stage changes the result by only a few LSBs and is easily lost in busy data. The stimulus therefore places lone non-neutral decisions on single odd and even stages (stage 9, stage 1, stage 2) between all-neutral samples. In each case exactly one output word must move, in exactly the right cycle. Clamp edges (0, 1, 1023, 1024), redundant pairs and the illegal 11 code are each set up as individual samples. A reset in the middle of a stream, with alignment registers still holding half-finished samples, shows that the output stays at zero until the new stream has filled.

// File: rtl/adc_corr_pkg.sv
`timescale 1ns/1ps
package adc_corr_pkg;
  // Two-bit stage decision codes (R1)
  localparam logic [1:0] DEC_NEG  = 2'b00;
  localparam logic [1:0] DEC_ZERO = 2'b01;
  localparam logic [1:0] DEC_POS  = 2'b10;

  // The upper bit alone marks +1, so the illegal 11 counts as +1 (R1)
  function automatic logic dec_is_pos(logic [1:0] c);
    return c[1];
  endfunction

  function automatic logic dec_is_neg(logic [1:0] c);
    return c == DEC_NEG;
  endfunction
endpackage

// File: rtl/stage_align.sv
`timescale 1ns/1ps
// Delays one stage decision by DEPTH rising edges (DEPTH >= 1)
module stage_align #(
  parameter int DEPTH = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] d_in,
  output logic [1:0] d_out
);
  logic [1:0] taps [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) taps[k] <= '0;
    end else begin
      taps[0] <= d_in;
      for (int k = 1; k < DEPTH; k++) taps[k] <= taps[k-1];
    end
  end

  assign d_out = taps[DEPTH-1];
endmodule

// File: rtl/corr_sum.sv
`timescale 1ns/1ps
// Weighted overlap-add of aligned decisions with mid-scale offset and clamp
module corr_sum
  import adc_corr_pkg::*;
#(
  parameter int NSTG  = 10,
  parameter int OUT_W = 10
) (
  input  logic [2*NSTG-1:0] dec_vec,
  output logic [OUT_W-1:0]  code
);
  localparam int SW = OUT_W + 2;
  localparam logic signed [SW-1:0] OFFSET = SW'(1) << (OUT_W - 1);
  localparam logic signed [SW-1:0] MAXC   = SW'((1 << OUT_W) - 1);

  logic signed [SW-1:0] acc;

  always_comb begin
    acc = OFFSET;
    for (int i = 0; i < NSTG; i++) begin
      if (dec_is_pos(dec_vec[2*i +: 2]))
        acc = acc + (SW'(1) << (NSTG - 1 - i));
      else if (dec_is_neg(dec_vec[2*i +: 2]))
        acc = acc - (SW'(1) << (NSTG - 1 - i));
    end
  end

  // Saturate to the output range (R5)
  always_comb begin
    if (acc < 0)
      code = '0;
    else if (acc > MAXC)
      code = '1;
    else
      code = acc[OUT_W-1:0];
  end
endmodule

// File: rtl/adc_pipe_corr.sv
`timescale 1ns/1ps
module adc_pipe_corr #(
  parameter int NSTG = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2*NSTG-1:0] stage_dec,
  output logic [NSTG-1:0]   code_out
);
  localparam int SLOTS = (NSTG + 1) / 2;
  localparam int LAST  = SLOTS - 1;
  localparam int CW    = $clog2(LAST + 2);

  logic [2*NSTG-1:0] aligned;
  logic [NSTG-1:0]   sum_code;
  logic [CW-1:0]     fill;

  // Stage i lands in slot i/2; delay it up to the last slot (R2)
  for (genvar i = 0; i < NSTG; i++) begin : g_align
    if (LAST - i/2 == 0) begin : g_direct
      assign aligned[2*i +: 2] = stage_dec[2*i +: 2];
    end else begin : g_delay
      stage_align #(.DEPTH(LAST - i/2)) u_align (
        .clk  (clk),
        .rst  (rst),
        .d_in (stage_dec[2*i +: 2]),
        .d_out(aligned[2*i +: 2])
      );
    end
  end

  corr_sum #(.NSTG(NSTG), .OUT_W(NSTG)) u_sum (
    .dec_vec(aligned),
    .code   (sum_code)
  );

  // Refill tracking after reset (R7)
  always_ff @(posedge clk) begin
    if (rst)
      fill <= '0;
    else if (fill != CW'(LAST))
      fill <= fill + 1'b1;
  end

  // Output register (R3)
  always_ff @(posedge clk) begin
    if (rst)
      code_out <= '0;
    else if (fill == CW'(LAST))
      code_out <= sum_code;
    else
      code_out <= '0;
  end
endmodule

// File: rtl/adc_pipe_corr_chk.sv
`timescale 1ns/1ps
module adc_pipe_corr_chk #(
  parameter int NSTG = 10
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      s0_dec,
  input logic [NSTG-1:0] code_out
);
  localparam int LAST = (NSTG + 1) / 2 - 1;
  localparam int CW   = $clog2(LAST + 3);

  logic [CW-1:0] cyc;
  logic [1:0]    hist [LAST+1];

  always_ff @(posedge clk) begin
    if (rst)
      cyc <= '0;
    else if (cyc <= CW'(LAST))
      cyc <= cyc + 1'b1;
  end

  always_ff @(posedge clk) begin
    hist[0] <= s0_dec;
    for (int k = 1; k <= LAST; k++) hist[k] <= hist[k-1];
  end

  // R7: first cycle after reset shows zero
  p_reset_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> code_out == '0);

  // R7: output held at zero while the pipeline refills
  p_fill_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (cyc <= CW'(LAST)) |-> code_out == '0);

  // R4: stage 0 at +1 puts the word in the upper half
  p_sign_pos_r4: assert property (@(posedge clk) disable iff (rst)
    (cyc > CW'(LAST) && hist[LAST][1]) |-> code_out[NSTG-1]);

  // R4: stage 0 at -1 puts the word in the lower half
  p_sign_neg_r4: assert property (@(posedge clk) disable iff (rst)
    (cyc > CW'(LAST) && hist[LAST] == 2'b00) |-> !code_out[NSTG-1]);

  // R5: a neutral stage 0 never reaches the lower clamp
  p_neutral_no_floor_r5: assert property (@(posedge clk) disable iff (rst)
    (cyc > CW'(LAST) && hist[LAST] == 2'b01) |-> code_out != '0);
endmodule

bind adc_pipe_corr adc_pipe_corr_chk #(.NSTG(NSTG)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .s0_dec  (stage_dec[1:0]),
  .code_out(code_out)
);

// File: tb/test_adc_pipe_corr.sv
`timescale 1ns/1ps
module test_adc_pipe_corr;
  localparam int NSTG  = 10;
  localparam int LAT   = 5;
  localparam int NSMAX = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst;
  logic [2*NSTG-1:0] stage_dec;
  logic [NSTG-1:0]   code_out;

  adc_pipe_corr #(.NSTG(NSTG)) i_adc_pipe_corr (
    .clk(clk), .rst(rst), .stage_dec(stage_dec), .code_out(code_out)
  );

  int    errors = 0;
  int    checks = 0;
  bit    done   = 0;
  int    smp [NSMAX][NSTG];
  string tag [NSMAX];
  int    ns;

  // Decision values -1, 0, +1; the value 2 stands for the illegal code 11
  function automatic logic [1:0] enc(int v);
    case (v)
      -1:      return 2'b00;
      0:       return 2'b01;
      1:       return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  function automatic int ref_code(int k);
    int acc = 512;
    for (int i = 0; i < NSTG; i++) begin
      if (smp[k][i] >= 1)       acc += 1 << (NSTG - 1 - i);
      else if (smp[k][i] == -1) acc -= 1 << (NSTG - 1 - i);
    end
    if (acc < 0)    acc = 0;
    if (acc > 1023) acc = 1023;
    return acc;
  endfunction

  task automatic check(int exp, string req);
    checks++;
    if (code_out !== exp[NSTG-1:0]) begin
      errors++;
      $display("FAIL %s: code_out=%0d expected=%0d at %0t", req, code_out, exp, $time);
    end
  endtask

  task automatic put(int k, int p [NSTG], string t);
    for (int i = 0; i < NSTG; i++) smp[k][i] = p[i];
    tag[k] = t;
  endtask

  task automatic put_one(int k, int stg, int v, string t);
    for (int i = 0; i < NSTG; i++) smp[k][i] = 0;
    if (stg >= 0) smp[k][stg] = v;
    tag[k] = t;
  endtask

  task automatic put_rand(int k, string t);
    for (int i = 0; i < NSTG; i++) smp[k][i] = int'($urandom_range(0, 3)) - 1;
    tag[k] = t;
  endtask

  task automatic drive(int cr);
    for (int i = 0; i < NSTG; i++) begin
      int k = cr - i / 2;
      stage_dec[2*i +: 2] = (k >= 0 && k < ns) ? enc(smp[k][i]) : 2'b01;
    end
  endtask

  // Called at a negedge with rst high; releases reset and streams samples
  task automatic run(bit drain);
    int last_cr = drain ? ns + LAT - 1 : ns - 1;
    for (int cr = 0; cr <= last_cr; cr++) begin
      if (cr == 0) rst = 1'b0;
      else @(negedge clk);
      if (cr < LAT) check(0, "R7");
      else          check(ref_code(cr - LAT), tag[cr - LAT]);
      drive(cr);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    stage_dec = '1;
    for (int r = 0; r < 3; r++) begin
      @(negedge clk);
      check(0, "R7");
    end
  endtask

  initial begin
    rst = 1'b1;
    stage_dec = '1;
    do_reset();

    // Segment 1: directed corner samples
    put_one(0, -1, 0, "R6");                                  // 512
    put(1, '{1,1,1,1,1,1,1,1,1,1}, "R5");                     // clamp high
    put(2, '{-1,-1,-1,-1,-1,-1,-1,-1,-1,-1}, "R5");           // clamp low
    put_one(3, 0, 1, "R5");                                   // 1024 -> 1023
    put(4, '{1,0,0,0,0,0,0,0,0,-1}, "R5");                    // exactly 1023
    put_one(5, 0, -1, "R5");                                  // exactly 0
    put(6, '{-1,0,0,0,0,0,0,0,0,1}, "R5");                    // 1
    put_one(7, -1, 0, "R6");
    put_one(8, 9, 1, "R2");                                   // 513, last slot
    put_one(9, 1, 1, "R2");                                   // 768, odd stage
    put(10, '{1,-1,0,0,0,0,0,0,0,0}, "R8");                   // 768
    put(11, '{0,1,0,0,0,0,0,0,0,0}, "R8");                    // 768
    put(12, '{0,0,0,-1,1,0,0,0,0,0}, "R8");                   // 480
    put(13, '{0,0,0,0,-1,0,0,0,0,0}, "R8");                   // 480
    put(14, '{2,-1,0,0,0,0,0,0,0,0}, "R1");                   // 11 as +1: 768
    put(15, '{-1,0,0,0,0,2,0,0,0,0}, "R1");                   // 16
    put_one(16, -1, 0, "R3");
    put_one(17, 2, 1, "R3");                                  // 640 in one cycle only
    put_one(18, -1, 0, "R3");
    for (int k = 19; k < 50; k++) put_rand(k, "R4");
    ns = 50;
    run(1'b1);

    // Segment 2: reset hits while samples are half aligned
    do_reset();
    for (int k = 0; k < 20; k++) put_rand(k, "R4");
    ns = 20;
    run(1'b0);
    do_reset();

    // Segment 3: refill after mid-stream reset
    for (int k = 0; k < 12; k++) put_rand(k, "R7");
    ns = 12;
    run(1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule